// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Error Queue

This block keeps the logged context of the first uncorrectable error a device reports. That context is a pointer to the status bit of the error, the four dwords of the packet header, the four dwords of any end-to-end prefix, and the requester source ID. A classification unit sends record requests. Each request carries exactly one status bit, its header and prefix dwords, and two flags. Software clears bits in the uncorrectable status register, and the configuration interface reports each such write with a strobe. That strobe decides whether the log stays, moves on to the next pending error, or clears.

Multiple header recording is switched on by an enable input. While it is on, an error that arrives while the error at the pointer is still unacknowledged is not lost. It waits in a FIFO queue and enters the log only after software clears the status bit at the pointer. On every status write, the block returns a one-cycle mask of status bits to set again. This puts back the status bits of queued errors that software may have cleared. When the queue is full, the block drops the new error and pulses an overflow output. The status register itself and the address decode are outside the block: the current status value is an input, and the re-set mask is an output.

Top module: `uerr_hdr_log`

## Requirements
- R1: After reset, `first_err_ptr`, `log_src`, `hdr_log`, `pfx_log`, `pfx_logged`, `sts_set_mask` and `hdr_overflow` are all zero.
- R2: A record that is not held back (see R5) loads the log on the next clock edge. `first_err_ptr` becomes the index of the lowest set bit of `rec_status`, and `log_src` becomes `rec_src`.
- R3: For a record with `rec_hdr_valid`=1, `hdr_log` dword i (bits 32i+31:32i) is `rec_hdr` dword i with its four bytes reversed. For a record with `rec_hdr_valid`=0, `hdr_log` is zero.
- R4: `pfx_log` takes `rec_pfx` with the bytes of each dword reversed, and `pfx_logged` becomes 1, only when both `rec_pfx_present` and `prefix_cap` are 1. In every other case `pfx_log` is zero and `pfx_logged` is 0.
- R5: While `mhr_en`=1 and `uncor_status[first_err_ptr]`=1, a record is appended to the queue and the log does not change.
- R6: A record held back under R5 while `QDEPTH` entries are already queued is discarded. `hdr_overflow` is 1 for exactly one cycle after it.
- R7: On `sts_wr` with `uncor_status[first_err_ptr]`=0, `mhr_en`=1 and a non-empty queue, `sts_set_mask` is the OR of the status of every queued entry for one cycle. The oldest entry then enters the log under R2 to R4, so entries leave in arrival order.
- R8: On `sts_wr` with `uncor_status[first_err_ptr]`=0 and either `mhr_en`=0 or an empty queue, `first_err_ptr`, `log_src`, `hdr_log`, `pfx_log` and `pfx_logged` are cleared.
- R9: On `sts_wr` with `uncor_status[first_err_ptr]`=1 and `mhr_en`=1, `sts_set_mask` is the OR of the queued statuses for one cycle, and the log does not change.
- R10: On `sts_wr` with `uncor_status[first_err_ptr]`=1 and `mhr_en`=0, the queue is emptied and `sts_set_mask` stays zero. A later write that clears the first-error bit then clears the log.
- R11: `mhr_capable` is 1 exactly when `QDEPTH` is greater than 0. With `QDEPTH`=0, `mhr_en` has no effect.
- R12: The user never asserts `rec_valid` and `sts_wr` in the same cycle, and never sends `rec_pfx_present`=1 together with `rec_hdr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mhr_en | input | 1 | Multiple header recording enable |
| prefix_cap | input | 1 | Device supports end-to-end prefixes |
| uncor_status | input | 32 | Current uncorrectable status register value |
| rec_valid | input | 1 | Record request |
| rec_status | input | 32 | One-hot status bit of the error |
| rec_src | input | 16 | Requester source ID |
| rec_hdr_valid | input | 1 | Header dwords are valid |
| rec_pfx_present | input | 1 | Error carries a prefix |
| rec_hdr | input | 128 | Header dwords, dword i at bits 32i+31:32i |
| rec_pfx | input | 128 | Prefix dwords, same layout |
| sts_wr | input | 1 | Status register write has completed |
| first_err_ptr | output | 5 | Bit index of the logged error |
| log_src | output | 16 | Source ID of the logged error |
| hdr_log | output | 128 | Header log, byte-reversed dwords |
| pfx_log | output | 128 | Prefix log, byte-reversed dwords |
| pfx_logged | output | 1 | Prefix log holds a valid prefix |
| sts_set_mask | output | 32 | One-cycle mask of status bits to set again |
| hdr_overflow | output | 1 | One-cycle pulse when an error is dropped |
| mhr_capable | output | 1 | Queue is present |

## Verification
Broken queue ordering or lost entries show up at the first status write that clears the first-error bit. The wrong pointer, source or header then appears on the log outputs one cycle after the strobe. A corrupt record or valid count in the queue shows up sooner, in `sts_set_mask` on any write while recording is enabled, again one cycle after the strobe. A queue that fails to empty on the no-recording path only becomes visible at a later clearing write, which loads stale data where a cleared log is expected. A wrong full threshold shows up as a missing or early `hdr_overflow` pulse on the record after the one that fills the queue.

// File: rtl/uhl_pkg.sv
package uhl_pkg;
   localparam int unsigned STS_W = 32;
   localparam int unsigned FEP_W = $clog2(STS_W);
   localparam int unsigned DW    = 32;
   localparam int unsigned NDW   = 4;
   localparam int unsigned LOG_W = DW * NDW;
   localparam int unsigned SRC_W = 16;

   typedef struct packed {
      logic [STS_W-1:0] status;
      logic [SRC_W-1:0] src;
      logic             hdr_valid;
      logic             pfx_present;
      logic [LOG_W-1:0] hdr;
      logic [LOG_W-1:0] pfx;
   } uhl_entry_t;

   // index of the lowest set bit
   function automatic logic [FEP_W-1:0] low_index(input logic [STS_W-1:0] s);
      logic [FEP_W-1:0] r;
      r = '0;
      for (int i = STS_W - 1; i >= 0; i--) begin
         if (s[i]) r = FEP_W'(i);
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] d);
      logic [DW-1:0] r;
      for (int b = 0; b < DW / 8; b++) begin
         r[8*b +: 8] = d[DW - 8*(b+1) +: 8];
      end
      return r;
   endfunction
endpackage

// File: rtl/uhl_queue.sv
module uhl_queue import uhl_pkg::*; #(
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   input  uhl_entry_t       din,
   output uhl_entry_t       dout,
   output logic             full,
   output logic             empty,
   output logic [STS_W-1:0] or_status
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   uhl_entry_t       mem [DEPTH];
   logic [DEPTH-1:0] vld;
   logic [AW-1:0]    rd_q, wr_q;
   logic [CW-1:0]    cnt_q;
   logic             push_ok, pop_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem   <= '{default: '0};
         vld   <= '0;
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         vld   <= '0;
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) begin
            mem[wr_q] <= din;
            vld[wr_q] <= 1'b1;
            wr_q      <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         end
         if (pop_ok) begin
            vld[rd_q] <= 1'b0;
            rd_q      <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_comb begin
      or_status = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld[i]) or_status = or_status | mem[i].status;
      end
   end
endmodule

// File: rtl/uhl_log_regs.sv
module uhl_log_regs import uhl_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  uhl_entry_t       ent,
   input  logic             prefix_cap,
   output logic [FEP_W-1:0] fep,
   output logic [SRC_W-1:0] src,
   output logic [LOG_W-1:0] hdr,
   output logic [LOG_W-1:0] pfx,
   output logic             pfx_flag
);
   logic take_pfx;
   assign take_pfx = ent.pfx_present && prefix_cap;

   always_ff @(posedge clk) begin
      if (!rst_n || (clear && !load)) begin
         fep      <= '0;
         src      <= '0;
         hdr      <= '0;
         pfx      <= '0;
         pfx_flag <= 1'b0;
      end else if (load) begin
         fep      <= low_index(ent.status);
         src      <= ent.src;
         pfx_flag <= take_pfx;
         for (int i = 0; i < NDW; i++) begin
            hdr[DW*i +: DW] <= ent.hdr_valid ? rev_bytes(ent.hdr[DW*i +: DW]) : '0;
            pfx[DW*i +: DW] <= take_pfx ? rev_bytes(ent.pfx[DW*i +: DW]) : '0;
         end
      end
   end
endmodule

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log import uhl_pkg::*; #(
   parameter int unsigned QDEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mhr_en,
   input  logic             prefix_cap,
   input  logic [STS_W-1:0] uncor_status,
   input  logic             rec_valid,
   input  logic [STS_W-1:0] rec_status,
   input  logic [SRC_W-1:0] rec_src,
   input  logic             rec_hdr_valid,
   input  logic             rec_pfx_present,
   input  logic [LOG_W-1:0] rec_hdr,
   input  logic [LOG_W-1:0] rec_pfx,
   input  logic             sts_wr,
   output logic [FEP_W-1:0] first_err_ptr,
   output logic [SRC_W-1:0] log_src,
   output logic [LOG_W-1:0] hdr_log,
   output logic [LOG_W-1:0] pfx_log,
   output logic             pfx_logged,
   output logic [STS_W-1:0] sts_set_mask,
   output logic             hdr_overflow,
   output logic             mhr_capable
);
   localparam bit HAS_Q = (QDEPTH > 0);

   if (QDEPTH > 64) begin : gen_bad_depth
      $error("uerr_hdr_log: QDEPTH must not exceed 64");
   end
   if (STS_W != 32 || DW % 8 != 0) begin : gen_bad_width
      $error("uerr_hdr_log: status must be 32 bits and dwords whole bytes");
   end

   uhl_entry_t       rec_ent, q_head, log_ent;
   logic             q_full, q_empty, q_push, q_pop, q_flush;
   logic [STS_W-1:0] q_or;
   logic             eff_mhr, fe_set, hold, advance, do_load, do_clear;

   assign rec_ent = '{status: rec_status, src: rec_src, hdr_valid: rec_hdr_valid,
                      pfx_present: rec_pfx_present, hdr: rec_hdr, pfx: rec_pfx};

   assign eff_mhr  = HAS_Q && mhr_en;
   assign fe_set   = uncor_status[first_err_ptr];
   assign hold     = eff_mhr && fe_set;
   assign q_push   = rec_valid && hold;
   assign advance  = sts_wr && !fe_set && eff_mhr && !q_empty;
   assign q_pop    = advance;
   assign q_flush  = sts_wr && fe_set && !eff_mhr;
   assign do_load  = (rec_valid && !hold) || advance;
   assign do_clear = sts_wr && !fe_set && !advance;
   assign log_ent  = advance ? q_head : rec_ent;
   assign mhr_capable = HAS_Q;

   if (HAS_Q) begin : gen_queue
      uhl_queue #(.DEPTH(QDEPTH)) u_queue (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (q_push),
         .pop       (q_pop),
         .flush     (q_flush),
         .din       (rec_ent),
         .dout      (q_head),
         .full      (q_full),
         .empty     (q_empty),
         .or_status (q_or)
      );
   end else begin : gen_no_queue
      assign q_head  = '0;
      assign q_full  = 1'b1;
      assign q_empty = 1'b1;
      assign q_or    = '0;
   end

   uhl_log_regs u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (do_load),
      .clear      (do_clear),
      .ent        (log_ent),
      .prefix_cap (prefix_cap),
      .fep        (first_err_ptr),
      .src        (log_src),
      .hdr        (hdr_log),
      .pfx        (pfx_log),
      .pfx_flag   (pfx_logged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_set_mask <= '0;
         hdr_overflow <= 1'b0;
      end else begin
         sts_set_mask <= (sts_wr && eff_mhr) ? q_or : '0;
         hdr_overflow <= q_push && q_full;
      end
   end
endmodule

// File: rtl/uhl_chk.sv
module uhl_chk import uhl_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             mhr_en,
   input logic             mhr_capable,
   input logic             prefix_cap,
   input logic [STS_W-1:0] uncor_status,
   input logic             rec_valid,
   input logic             rec_hdr_valid,
   input logic             rec_pfx_present,
   input logic             sts_wr,
   input logic [FEP_W-1:0] first_err_ptr,
   input logic [LOG_W-1:0] hdr_log,
   input logic             pfx_logged,
   input logic [STS_W-1:0] sts_set_mask,
   input logic             hdr_overflow
);
   assert_no_coincide_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rec_valid && sts_wr));

   assert_pfx_needs_hdr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_pfx_present |-> rec_hdr_valid);

   assert_hold_on_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && mhr_en && mhr_capable && uncor_status[first_err_ptr]
      |=> $stable(hdr_log) && $stable(first_err_ptr));

   assert_keep_on_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr && uncor_status[first_err_ptr]
      |=> $stable(hdr_log) && $stable(first_err_ptr));

   assert_clear_log_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr && !uncor_status[first_err_ptr] && !mhr_en
      |=> first_err_ptr == '0 && hdr_log == '0 && !pfx_logged);

   assert_mask_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sts_set_mask != '0 |-> $past(sts_wr && mhr_en));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_overflow |-> $past(rec_valid && mhr_en && uncor_status[first_err_ptr]));

   assert_pfx_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfx_logged) |-> $past(prefix_cap));
endmodule

bind uerr_hdr_log uhl_chk u_chk (.*);

// File: tb/uerr_hdr_log_tb.sv
`timescale 1ns/1ps
module uerr_hdr_log_tb;
   localparam int QD = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mhr_en = 1'b0, prefix_cap = 1'b0;
   logic [31:0]  uncor_status = '0;
   logic         rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
   logic [31:0]  rec_status = '0;
   logic [15:0]  rec_src = '0;
   logic [127:0] rec_hdr = '0, rec_pfx = '0;
   logic         sts_wr = 1'b0;
   logic [4:0]   first_err_ptr;
   logic [15:0]  log_src;
   logic [127:0] hdr_log, pfx_log;
   logic         pfx_logged, hdr_overflow, mhr_capable;
   logic [31:0]  sts_set_mask;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   uerr_hdr_log #(.QDEPTH(QD)) u_dut (.*);

   // {status, hdr_valid, pfx_present, prefix_cap, hdr_seed, pfx_seed}
   localparam logic [98:0] VEC [6] = '{
      {32'h0000_0001, 1'b1, 1'b0, 1'b0, 32'h0102_0304, 32'h0000_0000},
      {32'h8000_0000, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678},
      {32'h0000_1000, 1'b1, 1'b1, 1'b0, 32'h5566_7788, 32'h9ABC_DEF0},
      {32'h0010_0000, 1'b0, 1'b0, 1'b1, 32'hFFEE_DDCC, 32'h0000_0000},
      {32'h0000_0010, 1'b1, 1'b1, 1'b1, 32'h0A0B_0C0D, 32'h1020_3040},
      {32'h0000_4000, 1'b1, 1'b0, 1'b1, 32'h7766_5544, 32'h3333_3333}
   };

   function automatic logic [127:0] blk(input logic [31:0] seed);
      for (int i = 0; i < 4; i++) blk[32*i +: 32] = seed + i * 32'h1111_1111;
   endfunction

   function automatic logic [127:0] swapped(input logic [31:0] seed);
      logic [127:0] b;
      b = blk(seed);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] x;
         x = b[32*i +: 32];
         swapped[32*i +: 32] = {x[7:0], x[15:8], x[23:16], x[31:24]};
      end
   endfunction

   function automatic logic [4:0] lowbit(input logic [31:0] s);
      lowbit = '0;
      for (int i = 31; i >= 0; i--) if (s[i]) lowbit = 5'(i);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic record(input logic [31:0] st, input logic [15:0] src, input logic hv,
                         input logic pp, input logic [31:0] hseed, input logic [31:0] pseed);
      @(negedge clk);
      rec_valid = 1'b1; rec_status = st; rec_src = src;
      rec_hdr_valid = hv; rec_pfx_present = pp;
      rec_hdr = blk(hseed); rec_pfx = blk(pseed);
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic status_write(input logic [31:0] st);
      @(negedge clk);
      uncor_status = st;
      sts_wr = 1'b1;
      @(negedge clk);
      sts_wr = 1'b0;
   endtask

   task automatic check_cleared(input string req);
      check(req, "ptr", 128'(first_err_ptr), 0);
      check(req, "src", 128'(log_src), 0);
      check(req, "hdr", hdr_log, 0);
      check(req, "pfx", pfx_log, 0);
      check(req, "pfxflag", 128'(pfx_logged), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R11 capability
      check_cleared("R1");
      check("R1", "mask", 128'(sts_set_mask), 0);
      check("R1", "ovf", 128'(hdr_overflow), 0);
      check("R11", "capable", 128'(mhr_capable), 1);

      // R2/R3/R4 table walk, recording disabled
      for (int v = 0; v < 6; v++) begin
         logic [31:0] st, hs, ps;
         logic hv, pp, cap, take;
         {st, hv, pp, cap, hs, ps} = VEC[v];
         prefix_cap = cap;
         record(st, 16'(16'h100 + v), hv, pp, hs, ps);
         take = pp && cap;
         check("R2", "ptr", 128'(first_err_ptr), 128'(lowbit(st)));
         check("R2", "src", 128'(log_src), 128'(16'h100 + v));
         check("R3", "hdr", hdr_log, hv ? swapped(hs) : 128'(0));
         check("R4", "pfx", pfx_log, take ? swapped(ps) : 128'(0));
         check("R4", "pfxflag", 128'(pfx_logged), 128'(take));
      end

      // R8 clear with recording disabled
      status_write(32'h0);
      check_cleared("R8");

      // queue walk, recording enabled
      mhr_en = 1'b1; prefix_cap = 1'b1;
      record(32'h8, 16'h00A, 1'b1, 1'b0, 32'hA0A1_A2A3, 32'h0);
      check("R2", "ptrA", 128'(first_err_ptr), 3);
      uncor_status = 32'h8;
      record(32'h20, 16'h00B, 1'b1, 1'b1, 32'hB0B1_B2B3, 32'hB4B5_B6B7);
      check("R5", "ptr held", 128'(first_err_ptr), 3);
      check("R5", "hdr held", hdr_log, swapped(32'hA0A1_A2A3));
      record(32'h80, 16'h00C, 1'b0, 1'b0, 32'hC0C1_C2C3, 32'h0);
      check("R5", "src held", 128'(log_src), 16'h00A);
      status_write(32'h8);
      check("R9", "mask", 128'(sts_set_mask), 128'(32'hA0));
      check("R9", "ptr kept", 128'(first_err_ptr), 3);
      status_write(32'h0);
      check("R7", "mask", 128'(sts_set_mask), 128'(32'hA0));
      check("R7", "ptrB", 128'(first_err_ptr), 5);
      check("R7", "srcB", 128'(log_src), 16'h00B);
      check("R7", "hdrB", hdr_log, swapped(32'hB0B1_B2B3));
      check("R4", "pfxB", pfx_log, swapped(32'hB4B5_B6B7));
      @(negedge clk);
      check("R7", "mask one cycle", 128'(sts_set_mask), 0);
      status_write(32'h80);
      check("R7", "maskC", 128'(sts_set_mask), 128'(32'h80));
      check("R7", "ptrC", 128'(first_err_ptr), 7);
      check("R3", "hdrC invalid", hdr_log, 0);
      status_write(32'h0);
      check("R8", "mask empty", 128'(sts_set_mask), 0);
      check_cleared("R8");

      // R6 overflow and FIFO order after fill
      record(32'h8, 16'h0AA, 1'b1, 1'b0, 32'h1111_0000, 32'h0);
      uncor_status = 32'h8;
      for (int k = 0; k < QD; k++) begin
         record(32'(1) << (8 + k), 16'(16'h200 + k), 1'b1, 1'b0, 32'(k), 32'h0);
         check("R6", "no ovf while room", 128'(hdr_overflow), 0);
      end
      record(32'h0100_0000, 16'h2FF, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
      check("R6", "ovf pulse", 128'(hdr_overflow), 1);
      @(negedge clk);
      check("R6", "ovf one cycle", 128'(hdr_overflow), 0);
      status_write(32'h0);
      check("R7", "mask full", 128'(sts_set_mask), 128'(32'h0000_FF00));
      check("R7", "fifo head ptr", 128'(first_err_ptr), 8);
      check("R7", "fifo head src", 128'(log_src), 16'h200);

      // R10 queue emptied when recording is off
      mhr_en = 1'b0;
      status_write(32'h100);
      check("R10", "mask zero", 128'(sts_set_mask), 0);
      check("R10", "ptr kept", 128'(first_err_ptr), 8);
      mhr_en = 1'b1;
      status_write(32'h0);
      check("R10", "mask after flush", 128'(sts_set_mask), 0);
      check_cleared("R10");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule